// File: doc/BRIEF.md
# Four-Lane Wavelet Row Pass

This block carries out one one-dimensional pass of one level of a two-dimensional discrete wavelet transform. Each input word carries four 16-bit samples, one from each of four adjacent rows at the same column. The block filters the four rows side by side. Each row is split into a low-pass half and a high-pass half by the reversible 5/3 lifting pair. Samples beyond either end of a row are supplied by mirroring.

Results leave as 64-bit words. Each word holds the four lanes' results for one output position, and it goes to a write address that stores the output transposed: an output position becomes a row of the stored image, and a row group becomes a column group. Feeding that stored image back through the same block therefore filters the other dimension and restores the original orientation.

The row length is the image side divided by two for each level already done, so every level works only on the low-low quadrant of the level before. Stored coefficients are 16-bit words whose binary point moves with the level. The image starts with 10 integer bits (sign included) and 6 fraction bits, and each level adds one integer bit. Setting `rescale` on the second pass of a level halves every result with rounding, which moves the data into the next level's format. At the top level the 16 stored bits then weigh 2^16 down to 2^1.

Top module: `wave_row_pass`

## Requirements
- R1: While reset is applied and after it is released, `busy`, `wr_en` and `done` are low until a pass is started.
- R2: A `start` seen while idle captures `size_log2`, `level` and `rescale`. `size_log2` is first clamped to the range 4..10. The row length is S = 2^L with L = clamped size minus `level`, but never less than 2. The pass then reads S rows in S/4 groups of four, and each group takes S words for columns 0..S-1. Bits [16k+15:16k] of the word for column c in group g hold row 4g+k, column c.
- R3: The high-pass result is d[i] = x[2i+1] - floor((x[2i] + x[2i+2]) / 2) for i = 0..S/2-1. The missing sample x[S] is replaced by x[S-2].
- R4: The low-pass result is s[i] = x[2i] + floor((d[i-1] + d[i] + 2) / 4). The missing d[-1] is replaced by d[0].
- R5: Both results of row group g for lane k go to bits [16k+15:16k] of a write word. The word for s[i] goes to address i*(S/4)+g, and the word for d[i] goes to address (S/2+i)*(S/4)+g. Each address in 0..S*S/4-1 is written exactly once per pass.
- R6: With `rescale` captured as 1, each result v is replaced by floor((v+1)/2) before it is stored.
- R7: A result above 32767 is stored as 32767, and a result below -32768 is stored as -32768.
- R8: `done` is high for a single cycle: the cycle right after the last write of the pass, with `wr_en` low. `busy` is low in that cycle.
- R9: A `start` raised while a pass is running does not change that pass's length, scaling or results.
- R10: `in_valid` while idle causes no write and does not affect the next pass.
- R11: A word is taken in every cycle where `busy` and `in_valid` are both high, until the pass has read all its words. Gaps in `in_valid` do not change the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a pass, taken only when idle |
| size_log2 | input | 4 | log2 of the full image side |
| level | input | 3 | Number of levels already completed |
| rescale | input | 1 | Halve each result with rounding, into the next level's format |
| in_valid | input | 1 | `in_word` holds the next column of the current row group |
| in_word | input | 64 | Four 16-bit samples, lane k in bits [16k+15:16k] |
| busy | output | 1 | A pass is running |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 18 | Transposed word address of the write |
| wr_data | output | 64 | Four 16-bit results, lane k in bits [16k+15:16k] |
| done | output | 1 | One-cycle pulse after the final write |

## Verification
Take column 2i+2 of a row group as accepted at a clock edge. The word for s[i] is on the write port in the cycle after that edge, and the word for d[i] is there one cycle later. The final column of a group produces the last pair of words, and they appear within the next three cycles. `done` follows one cycle after the pass's final write. The write order varies with the gaps in `in_valid`. For that reason the bench does not time each result. It samples the write port on every falling edge and matches each write against an expected-result table by address, marking each address as it is seen. Only the `done` check looks at timing: it checks the write port's value on the sample just before `done` and on the sample where `done` is high.

// File: rtl/wrp_pkg.sv
package wrp_pkg;
  localparam int SMP_W    = 16;
  localparam int LANES    = 4;
  localparam int WORD_W   = SMP_W * LANES;
  localparam int MAX_LOG2 = 10;
  localparam int MIN_LOG2 = 4;
  localparam int LOG_W    = 4;
  localparam int LVL_W    = 3;
  localparam int ACC_W    = SMP_W + 4;
  localparam int ADDR_W   = 2 * MAX_LOG2 - 2;

  typedef struct packed {
    logic              vld;
    logic [ADDR_W-1:0] addr;
    logic [WORD_W-1:0] data;
  } wr_ent_t;

  // Optional halving with round-half-up, then clamp to the sample range.
  function automatic logic [SMP_W-1:0] fit_sample(input logic signed [ACC_W-1:0] v,
                                                  input logic halve);
    logic signed [ACC_W-1:0] t;
    t = halve ? ((v + $signed(ACC_W'(1))) >>> 1) : v;
    if ((&t[ACC_W-1:SMP_W-1]) || !(|t[ACC_W-1:SMP_W-1]))
      return t[SMP_W-1:0];
    else if (t[ACC_W-1])
      return {1'b1, {(SMP_W-1){1'b0}}};
    else
      return {1'b0, {(SMP_W-1){1'b1}}};
  endfunction
endpackage

// File: rtl/wrp_ctrl.sv
module wrp_ctrl
  import wrp_pkg::*;
#(
  parameter int MAXL = MAX_LOG2,
  parameter int MINL = MIN_LOG2,
  parameter int LW   = LOG_W,
  parameter int VW   = LVL_W,
  parameter int AW   = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          start,
  input  logic [LW-1:0] size_log2,
  input  logic [VW-1:0] level,
  input  logic          rescale,
  input  logic          in_valid,
  input  logic          q_empty,
  output logic          busy,
  output logic          done,
  output logic          acc,
  output logic          col_even,
  output logic          step_pair,
  output logic          step_first,
  output logic          step_last,
  output logic          resc_q,
  output logic [AW-1:0] lo_addr,
  output logic [AW-1:0] hi_addr
);
  localparam int CW = MAXL;
  localparam int GW = MAXL - 2;
  localparam int RW = MAXL + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DRAIN} st_e;

  st_e           st_q, st_n;
  logic [LW-1:0] len_q, len_n, len_c, sz_c;
  logic          resc_n, done_q, done_n;
  logic [CW-1:0] col_q, col_n, col_max, idx;
  logic [GW-1:0] grp_q, grp_n, grp_max;
  logic [RW-1:0] row_len, half;
  logic [LW-1:0] shamt;
  logic [AW:0]   tot;

  // Effective row length from the clamped size and the level.
  always_comb begin
    if (size_log2 < LW'(MINL))      sz_c = LW'(MINL);
    else if (size_log2 > LW'(MAXL)) sz_c = LW'(MAXL);
    else                            sz_c = size_log2;
    if ({1'b0, sz_c} < ((LW+1)'(level) + (LW+1)'(2))) len_c = LW'(2);
    else                                              len_c = sz_c - LW'(level);
  end

  assign row_len = RW'(1) << len_q;
  assign half    = row_len >> 1;
  assign col_max = CW'(row_len - RW'(1));
  assign grp_max = GW'((row_len >> 2) - RW'(1));
  assign shamt   = len_q - LW'(2);
  assign tot     = (AW+1)'(1) << (({1'b0, len_q} << 1) - (LW+1)'(2));

  assign busy       = (st_q != ST_IDLE);
  assign done       = done_q;
  assign acc        = (st_q == ST_RUN) && in_valid;
  assign col_even   = !col_q[0];
  assign step_pair  = acc && col_even && (col_q != '0);
  assign step_first = acc && (col_q == CW'(2));
  assign step_last  = acc && (col_q == col_max);

  assign idx     = step_last ? CW'(half - RW'(1)) : ((col_q >> 1) - CW'(1));
  assign lo_addr = (AW'(idx) << shamt) + AW'(grp_q);
  assign hi_addr = ((AW'(half) + AW'(idx)) << shamt) + AW'(grp_q);

  always_comb begin
    st_n   = st_q;
    len_n  = len_q;
    resc_n = resc_q;
    col_n  = col_q;
    grp_n  = grp_q;
    done_n = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n   = ST_RUN;
          len_n  = len_c;
          resc_n = rescale;
          col_n  = '0;
          grp_n  = '0;
        end
      end
      ST_RUN: begin
        if (acc) begin
          if (col_q == col_max) begin
            col_n = '0;
            if (grp_q == grp_max) begin
              grp_n = '0;
              st_n  = ST_DRAIN;
            end else begin
              grp_n = grp_q + GW'(1);
            end
          end else begin
            col_n = col_q + CW'(1);
          end
        end
      end
      ST_DRAIN: begin
        if (q_empty) begin
          st_n   = ST_IDLE;
          done_n = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      st_q   <= ST_IDLE;
      len_q  <= LW'(2);
      resc_q <= 1'b0;
      col_q  <= '0;
      grp_q  <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      len_q  <= len_n;
      resc_q <= resc_n;
      col_q  <= col_n;
      grp_q  <= grp_n;
      done_q <= done_n;
    end
  end

  // R5: every issued address falls inside the pass's transposed region.
  a_r5_addr_in_range: assert property (@(posedge clk) disable iff (!rst_sn)
    (step_pair || step_last) |-> (({1'b0, hi_addr} < tot) && ({1'b0, lo_addr} < tot)));

  // R9: a start while running leaves the captured settings alone.
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rst_sn)
    (busy && start) |=> ($stable(len_q) && $stable(resc_q)));
endmodule

// File: rtl/wrp_lane.sv
module wrp_lane
  import wrp_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int AC = ACC_W
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          acc,
  input  logic          col_even,
  input  logic          step_pair,
  input  logic          step_first,
  input  logic          step_last,
  input  logic          halve,
  input  logic [SW-1:0] x_in,
  output logic [SW-1:0] lo_out,
  output logic [SW-1:0] hi_out
);
  logic [SW-1:0]        xe_q, xe_n, xo_q, xo_n;
  logic signed [AC-1:0] dp_q, dp_n;
  logic signed [AC-1:0] a_w, o_w, b_w, x_w, xe_w, xo_w, d_w, dprev, s_w;

  assign x_w  = {{(AC-SW){x_in[SW-1]}}, x_in};
  assign xe_w = {{(AC-SW){xe_q[SW-1]}}, xe_q};
  assign xo_w = {{(AC-SW){xo_q[SW-1]}}, xo_q};

  // Even arrival: (x[2i], x[2i+1], x[2i+2]); last column mirrors x[S-2].
  assign a_w   = xe_w;
  assign o_w   = step_last ? x_w  : xo_w;
  assign b_w   = step_last ? xe_w : x_w;
  assign d_w   = o_w - ((a_w + b_w) >>> 1);
  assign dprev = step_first ? d_w : dp_q;
  assign s_w   = a_w + ((dprev + d_w + $signed(AC'(2))) >>> 2);

  assign lo_out = fit_sample(s_w, halve);
  assign hi_out = fit_sample(d_w, halve);

  always_comb begin
    xe_n = xe_q;
    xo_n = xo_q;
    dp_n = dp_q;
    if (acc) begin
      if (col_even) xe_n = x_in;
      else          xo_n = x_in;
      if (step_pair) dp_n = d_w;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      xe_q <= '0;
      xo_q <= '0;
      dp_q <= '0;
    end else begin
      xe_q <= xe_n;
      xo_q <= xo_n;
      dp_q <= dp_n;
    end
  end

  // R4: the d[-1] substitution is applied only on the first pair of a row.
  a_r4_first_is_pair: assert property (@(posedge clk) disable iff (!rst_sn)
    step_first |-> step_pair);
  // R3: the mirrored last pair is produced on an odd column.
  a_r3_last_is_odd: assert property (@(posedge clk) disable iff (!rst_sn)
    step_last |-> !col_even);
endmodule

// File: rtl/wrp_outq.sv
module wrp_outq
  import wrp_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int WW = WORD_W
) (
  input  logic          clk,
  input  logic          rst_sn,
  input  logic          step_pair,
  input  logic          step_last,
  input  logic [AW-1:0] lo_addr,
  input  logic [AW-1:0] hi_addr,
  input  logic [WW-1:0] lo_word,
  input  logic [WW-1:0] hi_word,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [WW-1:0] wr_data,
  output logic          q_empty
);
  wr_ent_t out_q, out_n, e0_q, e0_n, e1_q, e1_n;
  wr_ent_t lo_e, hi_e;

  assign lo_e = '{vld: 1'b1, addr: lo_addr, data: lo_word};
  assign hi_e = '{vld: 1'b1, addr: hi_addr, data: hi_word};

  always_comb begin
    out_n = '0;
    e0_n  = e0_q;
    e1_n  = e1_q;
    if (step_pair) begin
      out_n = lo_e;
      e0_n  = hi_e;
      e1_n  = '0;
    end else if (step_last) begin
      if (e0_q.vld) begin
        out_n = e0_q;
        e0_n  = lo_e;
        e1_n  = hi_e;
      end else begin
        out_n = lo_e;
        e0_n  = hi_e;
        e1_n  = '0;
      end
    end else begin
      out_n = e0_q;
      e0_n  = e1_q;
      e1_n  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      out_q <= '0;
      e0_q  <= '0;
      e1_q  <= '0;
    end else begin
      out_q <= out_n;
      e0_q  <= e0_n;
      e1_q  <= e1_n;
    end
  end

  assign wr_en   = out_q.vld;
  assign wr_addr = out_q.addr;
  assign wr_data = out_q.data;
  assign q_empty = !e0_q.vld && !e1_q.vld;

  // R5: a new pair never arrives while an earlier result still waits.
  a_r5_no_collision: assert property (@(posedge clk) disable iff (!rst_sn)
    step_pair |-> q_empty);
  // R5: the last pair never lands on a full queue.
  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_sn)
    step_last |-> !e1_q.vld);
endmodule

// File: rtl/wave_row_pass.sv
module wave_row_pass
  import wrp_pkg::*;
#(
  parameter int SW = SMP_W,
  parameter int NL = LANES,
  parameter int LW = LOG_W,
  parameter int VW = LVL_W,
  parameter int AW = ADDR_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [LW-1:0]    size_log2,
  input  logic [VW-1:0]    level,
  input  logic             rescale,
  input  logic             in_valid,
  input  logic [SW*NL-1:0] in_word,
  output logic             busy,
  output logic             wr_en,
  output logic [AW-1:0]    wr_addr,
  output logic [SW*NL-1:0] wr_data,
  output logic             done
);
  localparam int WW = SW * NL;

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic          acc, col_even, step_pair, step_first, step_last, resc_q, q_empty;
  logic [AW-1:0] lo_addr, hi_addr;
  logic [WW-1:0] lo_word, hi_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  wrp_ctrl #(.LW(LW), .VW(VW), .AW(AW)) u_ctrl (
    .clk(clk), .rst_sn(rst_sn), .start(start), .size_log2(size_log2),
    .level(level), .rescale(rescale), .in_valid(in_valid), .q_empty(q_empty),
    .busy(busy), .done(done), .acc(acc), .col_even(col_even),
    .step_pair(step_pair), .step_first(step_first), .step_last(step_last),
    .resc_q(resc_q), .lo_addr(lo_addr), .hi_addr(hi_addr)
  );

  for (genvar k = 0; k < NL; k++) begin : g_lane
    wrp_lane #(.SW(SW)) u_lane (
      .clk(clk), .rst_sn(rst_sn), .acc(acc), .col_even(col_even),
      .step_pair(step_pair), .step_first(step_first), .step_last(step_last),
      .halve(resc_q), .x_in(in_word[k*SW +: SW]),
      .lo_out(lo_word[k*SW +: SW]), .hi_out(hi_word[k*SW +: SW])
    );
  end

  wrp_outq #(.AW(AW), .WW(WW)) u_outq (
    .clk(clk), .rst_sn(rst_sn), .step_pair(step_pair), .step_last(step_last),
    .lo_addr(lo_addr), .hi_addr(hi_addr), .lo_word(lo_word), .hi_word(hi_word),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .q_empty(q_empty)
  );

  // R8: completion is flagged only right after a write.
  a_r8_done_after_write: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> $past(wr_en));
  // R8: the completion cycle carries no write and the block is idle.
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_sn)
    done |-> (!wr_en && !busy));
  // R10: nothing is written while idle.
  a_r10_idle_no_write: assert property (@(posedge clk) disable iff (!rst_sn)
    !busy |-> !wr_en);
endmodule

// File: tb/wave_row_pass_tb_top.sv
module wave_row_pass_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  size_log2 = '0;
  logic [2:0]  level = '0;
  logic        rescale = 1'b0;
  logic        in_valid = 1'b0;
  logic [63:0] in_word = '0;
  logic        busy, wr_en, done;
  logic [17:0] wr_addr;
  logic [63:0] wr_data;

  always #4 clk = ~clk;

  wave_row_pass dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .size_log2(size_log2), .level(level),
    .rescale(rescale), .in_valid(in_valid), .in_word(in_word), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done)
  );

  int          checks = 0;
  int          fails = 0;
  int          cyc = 0;
  int          img [0:31][0:31];
  logic [63:0] exp_mem [0:255];
  bit          seen [0:255];
  int          cur_s = 4;
  int          cur_total = 4;
  int          nwr = 0;
  bit          done_seen = 1'b0;
  bit          prev_wr = 1'b0;
  bit          idle_win = 1'b0;
  int          win_wr = 0;
  string       pass_tag = "";

  task automatic chk(bit ok, string req, longint act, longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int fixv(int v, bit h);
    int t;
    t = h ? ((v + 1) >>> 1) : v;
    if (t > 32767) t = 32767;
    if (t < -32768) t = -32768;
    return t;
  endfunction

  function automatic int gen(int mode, int r, int c);
    case (mode)
      0: return int'($urandom_range(65535)) - 32768;
      1: return r * 37 + c * 5 - 300;
      2: return ((c % 2 == 0) ^ (r % 2 == 1)) ? -32768 : 32767;
      default: return int'($urandom_range(1023)) - 512;
    endcase
  endfunction

  task automatic build_expected(int s, bit h);
    int d [0:15];
    for (int a = 0; a < 256; a++) begin
      exp_mem[a] = '0;
      seen[a] = 1'b0;
    end
    for (int g = 0; g < s / 4; g++) begin
      for (int k = 0; k < 4; k++) begin
        int r;
        r = 4 * g + k;
        for (int i = 0; i < s / 2; i++) begin
          int xb;
          xb = (2 * i + 2 < s) ? img[r][2 * i + 2] : img[r][s - 2];
          d[i] = img[r][2 * i + 1] - ((img[r][2 * i] + xb) >>> 1);
        end
        for (int i = 0; i < s / 2; i++) begin
          int sv;
          int dm;
          dm = (i == 0) ? d[0] : d[i - 1];
          sv = img[r][2 * i] + ((dm + d[i] + 2) >>> 2);
          exp_mem[i * (s / 4) + g][16 * k +: 16] = 16'(fixv(sv, h));
          exp_mem[(s / 2 + i) * (s / 4) + g][16 * k +: 16] = 16'(fixv(d[i], h));
        end
      end
    end
  endtask

  // Sample away from the active edge; every write is matched by address.
  always @(negedge clk) begin
    cyc++;
    if (wr_en) begin
      nwr++;
      if (idle_win) win_wr++;
      if (int'(wr_addr) >= cur_total) begin
        chk(1'b0, "R5 address range", longint'(wr_addr), longint'(cur_total - 1));
      end else if (seen[wr_addr]) begin
        chk(1'b0, "R5 duplicate address", longint'(wr_addr), 0);
      end else begin
        string tg;
        seen[wr_addr] = 1'b1;
        if (pass_tag != "") tg = pass_tag;
        else if (int'(wr_addr) / (cur_s / 4) >= cur_s / 2) tg = "R3 high-pass";
        else tg = "R4 low-pass";
        chk(wr_data == exp_mem[wr_addr], tg, longint'(wr_data), longint'(exp_mem[wr_addr]));
      end
    end
    if (done) begin
      done_seen = 1'b1;
      chk(prev_wr && !wr_en && !busy, "R8 done timing",
          longint'({prev_wr, wr_en, busy}), 64'h4);
    end
    prev_wr = wr_en;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic run_pass(int sz, int lvl, bit resc, int mode, bit gaps, bit poke, string tg);
    int szc, len, s, wait_c;
    szc = (sz < 4) ? 4 : ((sz > 10) ? 10 : sz);
    len = szc - lvl;
    if (len < 2) len = 2;
    s = 1 << len;
    for (int r = 0; r < s; r++)
      for (int c = 0; c < s; c++)
        img[r][c] = gen(mode, r, c);
    build_expected(s, resc);
    cur_s = s;
    cur_total = s * s / 4;
    nwr = 0;
    done_seen = 1'b0;
    pass_tag = tg;
    @(posedge clk); #1;
    start = 1'b1; size_log2 = 4'(sz); level = 3'(lvl); rescale = resc;
    @(posedge clk); #1;
    start = 1'b0;
    for (int g = 0; g < s / 4; g++) begin
      for (int c = 0; c < s; c++) begin
        if (gaps) begin
          while ($urandom_range(3) == 0) begin
            in_valid = 1'b0;
            @(posedge clk); #1;
          end
        end
        in_valid = 1'b1;
        for (int k = 0; k < 4; k++) in_word[16 * k +: 16] = 16'(img[4 * g + k][c]);
        if (poke && g == 0 && c == 3) begin
          start = 1'b1; size_log2 = 4'(sz + 1); level = 3'd0; rescale = !resc;
        end
        @(posedge clk); #1;
        start = 1'b0;
      end
    end
    in_valid = 1'b0;
    wait_c = 0;
    while (!done_seen && wait_c < 200) begin
      @(posedge clk); #1;
      wait_c++;
    end
    chk(done_seen, "R8 done reached", longint'(done_seen), 1);
    chk(nwr == cur_total, poke ? "R9 write count" : (gaps ? "R11 write count" : "R2 write count"),
        longint'(nwr), longint'(cur_total));
    pass_tag = "";
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !wr_en && !done, "R1 reset state", longint'({busy, wr_en, done}), 0);

    run_pass(4, 0, 1'b0, 0, 1'b0, 1'b0, "");
    run_pass(5, 0, 1'b1, 0, 1'b1, 1'b0, "R6 rescale");
    run_pass(10, 6, 1'b0, 1, 1'b0, 1'b0, "");
    run_pass(4, 3, 1'b0, 0, 1'b0, 1'b0, "R2 short row");
    run_pass(3, 0, 1'b0, 2, 1'b0, 1'b0, "R7 saturation");
    run_pass(5, 0, 1'b1, 2, 1'b1, 1'b0, "R7 saturation rescaled");
    run_pass(4, 0, 1'b1, 1, 1'b0, 1'b0, "R6 rescale ramp");

    // R10: traffic while idle must be ignored.
    idle_win = 1'b1;
    win_wr = 0;
    for (int n = 0; n < 20; n++) begin
      @(posedge clk); #1;
      in_valid = 1'b1;
      in_word = {$urandom, $urandom};
    end
    @(posedge clk); #1;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    idle_win = 1'b0;
    chk(win_wr == 0 && !busy, "R10 idle writes", longint'(win_wr), 0);
    run_pass(4, 0, 1'b0, 3, 1'b0, 1'b0, "R10 pass after idle traffic");

    // R9: start while running is ignored.
    run_pass(4, 0, 1'b0, 0, 1'b1, 1'b1, "R9 start while busy");

    for (int t = 0; t < 6; t++) begin
      run_pass(4 + int'($urandom_range(1)), int'($urandom_range(1)) * (t % 2),
               1'(($urandom_range(1))), (t % 2 == 0) ? 0 : 3, 1'b1, 1'b0, "");
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule